// File: doc/BRIEF.md
# Decade Frequency Divider with Selectable Slow Output

This block derives a family of square waves from one reference clock (10 MHz in the intended use). It produces a copy of the reference and a fixed half-rate output (5 MHz). It also produces a fixed output at the reference divided by the radix (1 MHz), plus one selectable output. A 3-bit code picks the selectable output from a chain of divide-by-radix decade stages, which gives 100 kHz down to 1 Hz at the default settings. Every divided output has 50% duty. Every output edge falls on a rising edge of the reference clock.

All counters form a single synchronous chain. Each decade stage advances only on the carry of the stage above it. The multiplexed slow level is retimed in two steps. First a register loads once per 1 MHz period, in the cycle after the 1 MHz carry. Then a register at the full reference rate takes that value. The two fixed outputs pass through two registers as well. This gives every divided output the same two-cycle latency from its counter. A new select code is latched only when the slowest stage wraps, which is the moment when every counter returns to zero. As a result, a change of code never cuts a pulse short.

Top module: `decade_clk_divider`

## Requirements
- R1: `clk_pass_o` follows `clk_i` at all times.
- R2: `half_o` is low for the first two clocks after reset is released. From then on it toggles on every clock, and its value after post-reset edge n equals n-2 modulo 2.
- R3: After post-reset edge n, `ref_div_o` is high exactly when ((n-2) mod RADIX) >= RADIX/2, and low when n < 2. This is a 50% duty square wave with period RADIX.
- R4: With an in-range code s (0 <= s < N_STAGES) in force, `slow_o` after edge n is high exactly when (floor((n-2)/RADIX^(s+1)) mod RADIX) >= RADIX/2. Code 0 is the fastest decade and each step up divides by RADIX again.
- R5: A code of N_STAGES or above holds `slow_o` low.
- R6: All divided outputs share a two-cycle latency from the counters. After reset, the first rises come on edge 3 (`half_o`), edge RADIX/2+2 (`ref_div_o`) and edge RADIX*RADIX/2+2 (`slow_o`, code 0).
- R7: `sel_i` is taken in during reset, and afterwards only on edges n where n is a multiple of RADIX^(N_STAGES+1), which is the wrap of the slowest stage. A code change in between has no effect on `slow_o` until that edge.
- R8: While `rst_i` is high at a clock edge, all divided outputs are low after that edge and all counters restart from zero.
- R9: `slow_o` only changes in a cycle in which `ref_div_o` falls from 1 to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock |
| rst_i | input | 1 | Synchronous reset, active high |
| sel_i | input | SEL_W | Decade code for the selectable output |
| clk_pass_o | output | 1 | Copy of the reference clock |
| half_o | output | 1 | Reference divided by 2 |
| ref_div_o | output | 1 | Reference divided by RADIX |
| slow_o | output | 1 | Selected decade output, low for out-of-range codes |

## Verification
The bench builds the block with RADIX=4 and N_STAGES=3, so the slowest stage wraps every 256 clocks. With these values, a full sweep of all eight select codes over two complete slow periods each takes only a few thousand cycles. The out-of-range codes 3 to 7 are exercised as well as the valid ones. The small radix also brings within reach several select changes that are deferred across a rollover, and each output's exact first-rise cycle after reset. Every sample is compared with closed-form expressions of the post-reset edge count.

// File: rtl/ddiv_pkg.sv
`timescale 1ns/1ps
package ddiv_pkg;

  // Next count of a modulo-radix counter.
  function automatic int unsigned wrap_inc(int unsigned cnt, int unsigned radix);
    return (cnt + 1 >= radix) ? 0 : cnt + 1;
  endfunction

  // Square-wave level of a count: low for the first half, high for the second.
  function automatic logic upper_half(int unsigned cnt, int unsigned radix);
    return (cnt >= radix / 2) ? 1'b1 : 1'b0;
  endfunction

endpackage

// File: rtl/ddiv_stage.sv
`timescale 1ns/1ps
module ddiv_stage #(
  parameter int unsigned RADIX = 10
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic en_i,
  output logic level_o,
  output logic carry_o
);
  localparam int unsigned CW = (RADIX > 1) ? $clog2(RADIX) : 1;

  logic [CW-1:0] cnt_q;
  logic          at_top;

  assign at_top  = (32'(cnt_q) == RADIX - 1);
  assign carry_o = en_i && at_top;
  assign level_o = ddiv_pkg::upper_half(32'(cnt_q), RADIX);

  always_ff @(posedge clk_i) begin
    if (rst_i)     cnt_q <= '0;
    else if (en_i) cnt_q <= CW'(ddiv_pkg::wrap_inc(32'(cnt_q), RADIX));
  end

  // R4
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !en_i |=> $stable(cnt_q));
  // R4
  carry_wrap_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    carry_o |=> (cnt_q == '0));
endmodule

// File: rtl/ddiv_retime.sv
`timescale 1ns/1ps
module ddiv_retime (
  input  logic clk_i,
  input  logic rst_i,
  input  logic load_i,
  input  logic d_i,
  output logic q_o
);
  logic stage_a_q;
  logic stage_b_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      stage_a_q <= 1'b0;
      stage_b_q <= 1'b0;
    end else begin
      if (load_i) stage_a_q <= d_i;
      stage_b_q <= stage_a_q;
    end
  end

  assign q_o = stage_b_q;

  // R9
  stage_a_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !load_i |=> $stable(stage_a_q));
  // R6
  stage_b_follow_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !$past(rst_i) |-> (stage_b_q == $past(stage_a_q)));
endmodule

// File: rtl/decade_clk_divider.sv
`timescale 1ns/1ps
module decade_clk_divider #(
  parameter int unsigned RADIX    = 10,
  parameter int unsigned N_STAGES = 6,
  parameter int unsigned SEL_W    = 3
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             clk_pass_o,
  output logic             half_o,
  output logic             ref_div_o,
  output logic             slow_o
);
  // Event wires brought out for the checks below.
  logic                half_q;
  logic                ref_lvl;
  logic                ref_tick;
  logic                ref_tick_d;
  logic [N_STAGES:0]   chain_en;
  logic [N_STAGES-1:0] slow_lvl;
  logic                roll;
  logic [SEL_W-1:0]    sel_q;
  logic                mux_lvl;

  assign clk_pass_o = clk_i;

  // Half-rate toggle.
  always_ff @(posedge clk_i) begin
    if (rst_i) half_q <= 1'b0;
    else       half_q <= ~half_q;
  end

  // Reference divided by RADIX, advancing every clock.
  ddiv_stage #(.RADIX(RADIX)) u_ref_div (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .en_i    (1'b1),
    .level_o (ref_lvl),
    .carry_o (ref_tick)
  );

  // Decade chain, each stage enabled by the carry of the one above.
  assign chain_en[0] = ref_tick;
  for (genvar g = 0; g < N_STAGES; g++) begin : g_decade
    ddiv_stage #(.RADIX(RADIX)) u_dec (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .en_i    (chain_en[g]),
      .level_o (slow_lvl[g]),
      .carry_o (chain_en[g+1])
    );
  end
  assign roll = chain_en[N_STAGES];

  // Select code is taken at reset and at the slowest wrap only.
  always_ff @(posedge clk_i) begin
    if (rst_i || roll) sel_q <= sel_i;
  end

  always_comb begin
    mux_lvl = 1'b0;
    for (int k = 0; k < int'(N_STAGES); k++) begin
      if (int'(sel_q) == k) mux_lvl = slow_lvl[k];
    end
  end

  // Load strobe one clock after the divided-reference carry.
  always_ff @(posedge clk_i) begin
    if (rst_i) ref_tick_d <= 1'b0;
    else       ref_tick_d <= ref_tick;
  end

  ddiv_retime u_rt_half (
    .clk_i (clk_i), .rst_i (rst_i), .load_i (1'b1), .d_i (half_q), .q_o (half_o)
  );
  ddiv_retime u_rt_ref (
    .clk_i (clk_i), .rst_i (rst_i), .load_i (1'b1), .d_i (ref_lvl), .q_o (ref_div_o)
  );
  ddiv_retime u_rt_slow (
    .clk_i (clk_i), .rst_i (rst_i), .load_i (ref_tick_d), .d_i (mux_lvl), .q_o (slow_o)
  );

  // R9
  slow_edge_on_ref_fall_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (slow_o != $past(slow_o)) |-> $fell(ref_div_o));
  // R7
  sel_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !roll |=> $stable(sel_q));
  // R5
  bad_code_low_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (int'($past(sel_q, 2)) >= int'(N_STAGES)) |-> !slow_o);
  // R2
  half_toggle_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$past(rst_i, 1) && !$past(rst_i, 2) && !$past(rst_i, 3)) |-> (half_o != $past(half_o)));
  // R8
  reset_low_chk: assert property (@(posedge clk_i)
    rst_i |=> (!half_o && !ref_div_o && !slow_o));
endmodule

// File: tb/decade_clk_divider_tb.sv
`timescale 1ns/1ps
module decade_clk_divider_tb;
  localparam int R  = 4;
  localparam int N  = 3;
  localparam int SW = 3;
  localparam int H  = R / 2;
  localparam int P  = R ** (N + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [SW-1:0] sel = '0;
  logic          clk_pass_o, half_o, ref_div_o, slow_o;

  int tests = 0;
  int fails = 0;
  int n = 0;
  int selm = 0, hist0 = 0, hist1 = 0, hist2 = 0;
  logic p_ref = 1'b0, p_slow = 1'b0;

  always #2.5 clk = ~clk;

  decade_clk_divider #(.RADIX(R), .N_STAGES(N), .SEL_W(SW)) u_dut (
    .clk_i (clk), .rst_i (rst), .sel_i (sel),
    .clk_pass_o (clk_pass_o), .half_o (half_o), .ref_div_o (ref_div_o), .slow_o (slow_o)
  );

  function automatic logic exp_half(int m);
    return (m < 0) ? 1'b0 : ((m % 2) == 1);
  endfunction
  function automatic logic exp_ref(int m);
    return (m < 0) ? 1'b0 : ((m % R) >= H);
  endfunction
  function automatic logic exp_slow(int m, int s);
    if (m < 0 || s >= N) return 1'b0;
    return ((m / (R ** (s + 1))) % R) >= H;
  endfunction

  task automatic chk(string req, logic act, logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s n=%0d actual=%0b expected=%0b", req, n, act, exp);
    end
  endtask
  task automatic chk_int(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(int s);
    @(negedge clk);
    rst = 1'b1;
    sel = SW'(s);
    repeat (4) begin
      @(posedge clk); #1;
      chk("R8 half", half_o, 1'b0);
      chk("R8 ref", ref_div_o, 1'b0);
      chk("R8 slow", slow_o, 1'b0);
    end
    @(negedge clk);
    rst = 1'b0;
    n = 0; selm = s; hist0 = s; hist1 = s; hist2 = s;
    p_ref = 1'b0; p_slow = 1'b0;
  endtask

  task automatic step();
    string tag;
    @(posedge clk);
    n++;
    if (n % P == 0) selm = int'(sel);
    hist2 = hist1; hist1 = hist0; hist0 = selm;
    #1;
    chk("R2", half_o, exp_half(n - 2));
    chk("R3", ref_div_o, exp_ref(n - 2));
    if (hist2 >= N)                tag = "R5";
    else if (int'(sel) != hist2)   tag = "R7";
    else                           tag = "R4";
    chk(tag, slow_o, exp_slow(n - 2, hist2));
    if (slow_o !== p_slow) chk("R9", p_ref & ~ref_div_o, 1'b1);
    p_ref = ref_div_o; p_slow = slow_o;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int r_half, r_ref, r_slow;
    // R1: pass-through in both clock phases
    do_reset(0);
    step();
    chk("R1 high", clk_pass_o, 1'b1);
    #2.5;
    chk("R1 low", clk_pass_o, 1'b0);

    // R6: first rising edges after reset
    do_reset(0);
    r_half = 0; r_ref = 0; r_slow = 0;
    for (int c = 1; c <= 3 * R * H; c++) begin
      step();
      if (r_half == 0 && half_o === 1'b1)    r_half = n;
      if (r_ref == 0 && ref_div_o === 1'b1)  r_ref = n;
      if (r_slow == 0 && slow_o === 1'b1)    r_slow = n;
    end
    chk_int("R6 half first rise", r_half, 3);
    chk_int("R6 ref first rise", r_ref, H + 2);
    chk_int("R6 slow first rise", r_slow, R * H + 2);

    // R4/R5: every code over two full slow periods
    for (int s = 0; s < (1 << SW); s++) begin
      do_reset(s);
      for (int c = 0; c < 2 * P + 4; c++) step();
    end

    // R7: codes changed between wraps take effect only at a wrap
    do_reset(2);
    for (int c = 0; c < 150; c++) step();
    @(negedge clk); sel = 3'd0;
    for (int c = 0; c < 400; c++) step();
    @(negedge clk); sel = 3'd5;
    for (int c = 0; c < 300; c++) step();
    @(negedge clk); sel = 3'd1;
    for (int c = 0; c < 300; c++) step();

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule